// File: doc/BRIEF.md
# Four-Register Sequential Processor

This block is a small processor that runs one instruction at a time. Each instruction goes through fetch, decode, execute and writeback before the next one is read. The machine state is four general registers, a program counter and a zero flag. Instructions come from a read-only store that the surrounding logic (here the testbench) fills through a load port before the program is started.

The instruction set has five operations: register or immediate move, add, subtract, multiply and compare. A start pulse clears the program counter and begins execution. The core stops by itself once the program counter reaches the program length given at the `prog_len` input. Every finished instruction raises a one-cycle retire strobe. The strobe carries the destination register and the written value, so an observer can follow the program instruction by instruction.

Top module: `seqcore`

## Requirements
- R1: After reset, all four registers, the zero flag and the retire strobe are 0, and `halted` is 1. The core stays halted until `start` is pulsed.
- R2: Instruction word fields: opcode in bits 15:13, destination register in bits 12:11, immediate-select in bit 10, source register in bits 9:8, signed 8-bit immediate in bits 7:0. Opcode 0 is move. With immediate-select at 1, move writes the sign-extended immediate. With it at 0, move copies the source register.
- R3: Opcode 1 (add), 2 (subtract) and 3 (multiply) write `dst op src` to the destination register, keeping only the low 16 bits.
- R4: Opcode 4 (compare) sets the zero flag when dst minus src is zero and clears it otherwise. It writes no register and retires with `retire_wr` at 0 and `retire_val` at 0.
- R5: Opcodes 5, 6 and 7 write zero to the destination register, whatever the other fields hold.
- R6: Only compare changes the zero flag. A move, arithmetic or unrecognised instruction leaves it as it was, even when its result is zero.
- R7: Each instruction takes exactly four cycles. The first retire comes four cycles after the cycle in which start is taken, and later retires come every four cycles. `retire` is high for one cycle, and the register update is visible in that same cycle.
- R8: When a fetch finds the program counter at or above `prog_len`, `halted` rises in the next cycle and no further retire occurs. With `prog_len` at 0, the core halts without retiring anything.
- R9: `start` clears the program counter and `halted` but keeps the registers and the zero flag. A start that lands on a writeback cycle cancels that write and its retire strobe, and execution restarts at word 0.
- R10: Add, subtract, multiply and compare always take the second operand from the source register and ignore immediate-select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Write enable for the instruction store |
| load_addr | input | PC_W | Instruction store write address |
| load_word | input | 16 | Instruction word to store |
| prog_len | input | PC_W+1 | Number of valid instructions (capped at store depth) |
| start | input | 1 | Restart pulse: clears program counter and halted |
| regs_flat | output | 4*REG_W | Register contents, register n in bits n*REG_W upward |
| zero_flag | output | 1 | Result of the last compare |
| halted | output | 1 | Core stopped |
| retire | output | 1 | One-cycle strobe per finished instruction |
| retire_wr | output | 1 | Retired instruction wrote a register |
| retire_idx | output | 2 | Destination register of the retired instruction |
| retire_val | output | REG_W | Value written (0 for compare) |

## Verification
The collision that matters is a start pulse arriving in the same cycle as a writeback. Both want to change architectural state at one clock edge: the start by resetting the program counter, the writeback by updating a register and raising the retire strobe. The bench counts cycles from a retire so that start is driven exactly in the writeback cycle of the following instruction. It then checks that no strobe appears, that the target register keeps its old value while other registers survive, and that the next retire is word 0 again, four cycles after the start.

// File: rtl/seqcore_pkg.sv
package seqcore_pkg;

    localparam int INSN_W = 16;
    localparam int IMM_W  = 8;
    localparam int NREG   = 4;
    localparam int RIDX_W = $clog2(NREG);

    localparam logic [2:0] OPC_MOV = 3'd0;
    localparam logic [2:0] OPC_ADD = 3'd1;
    localparam logic [2:0] OPC_SUB = 3'd2;
    localparam logic [2:0] OPC_MUL = 3'd3;
    localparam logic [2:0] OPC_CMP = 3'd4;

    typedef struct packed {
        logic [2:0]        op;
        logic [RIDX_W-1:0] dst;
        logic              use_imm;
        logic [RIDX_W-1:0] src;
        logic [IMM_W-1:0]  imm;
    } insn_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_WB
    } stage_t;

endpackage

// File: rtl/seqcore_imem.sv
module seqcore_imem #(
    parameter int DEPTH = 32,
    parameter int AW    = 5,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_addr] <= wr_data;
    end

    assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/seqcore_alu.sv
module seqcore_alu
    import seqcore_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [2:0]       op,
    input  logic [REG_W-1:0] a,
    input  logic [REG_W-1:0] b,
    input  logic [IMM_W-1:0] imm,
    input  logic             use_imm,
    output logic [REG_W-1:0] res,
    output logic             wen,
    output logic             is_cmp,
    output logic             cmp_zero
);
    logic [REG_W-1:0] imm_ext;
    logic [REG_W-1:0] diff;

    assign imm_ext = {{(REG_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign diff    = a - b;

    always_comb begin
        res      = '0;
        wen      = 1'b1;
        is_cmp   = 1'b0;
        cmp_zero = (diff == '0);
        case (op)
            OPC_MOV: res = use_imm ? imm_ext : b;
            OPC_ADD: res = a + b;
            OPC_SUB: res = diff;
            OPC_MUL: res = a * b;
            OPC_CMP: begin
                wen    = 1'b0;
                is_cmp = 1'b1;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/seqcore.sv
module seqcore
    import seqcore_pkg::*;
#(
    parameter  int REG_W      = 16,
    parameter  int IMEM_DEPTH = 32,
    localparam int PC_W       = $clog2(IMEM_DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_en,
    input  logic [PC_W-1:0]       load_addr,
    input  logic [INSN_W-1:0]     load_word,
    input  logic [PC_W:0]         prog_len,
    input  logic                  start,
    output logic [NREG*REG_W-1:0] regs_flat,
    output logic                  zero_flag,
    output logic                  halted,
    output logic                  retire,
    output logic                  retire_wr,
    output logic [RIDX_W-1:0]     retire_idx,
    output logic [REG_W-1:0]      retire_val
);
    localparam logic [PC_W:0] DEPTH_CAP = (PC_W+1)'(IMEM_DEPTH);

    typedef struct packed {
        stage_t                       st;
        logic [PC_W:0]                pc;
        insn_t                        ir;
        logic [REG_W-1:0]             opa;
        logic [REG_W-1:0]             opb;
        logic [REG_W-1:0]             res;
        logic                         wen;
        logic                         is_cmp;
        logic                         zres;
        logic [NREG-1:0][REG_W-1:0]   regs;
        logic                         zero;
        logic                         halted;
        logic                         ret;
        logic                         ret_wr;
        logic [RIDX_W-1:0]            ret_idx;
        logic [REG_W-1:0]             ret_val;
    } core_t;

    core_t q, d;

    logic [INSN_W-1:0] fetch_word;
    logic [PC_W:0]     len_eff;
    logic [REG_W-1:0]  alu_res;
    logic              alu_wen, alu_cmp, alu_zero;

    seqcore_imem #(.DEPTH(IMEM_DEPTH), .AW(PC_W), .DW(INSN_W)) u_imem (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_addr (load_addr),
        .wr_data (load_word),
        .rd_addr (q.pc[PC_W-1:0]),
        .rd_data (fetch_word)
    );

    seqcore_alu #(.REG_W(REG_W)) u_alu (
        .op       (q.ir.op),
        .a        (q.opa),
        .b        (q.opb),
        .imm      (q.ir.imm),
        .use_imm  (q.ir.use_imm),
        .res      (alu_res),
        .wen      (alu_wen),
        .is_cmp   (alu_cmp),
        .cmp_zero (alu_zero)
    );

    assign len_eff = (prog_len > DEPTH_CAP) ? DEPTH_CAP : prog_len;

    always_comb begin
        d     = q;
        d.ret = 1'b0;
        if (start) begin
            d.pc     = '0;
            d.halted = 1'b0;
            d.st     = ST_FETCH;
        end else begin
            case (q.st)
                ST_FETCH: begin
                    if (q.pc >= len_eff) begin
                        d.halted = 1'b1;
                        d.st     = ST_IDLE;
                    end else begin
                        d.ir = insn_t'(fetch_word);
                        d.pc = q.pc + 1'b1;
                        d.st = ST_DECODE;
                    end
                end
                ST_DECODE: begin
                    d.opa = q.regs[q.ir.dst];
                    d.opb = q.regs[q.ir.src];
                    d.st  = ST_EXEC;
                end
                ST_EXEC: begin
                    d.res    = alu_res;
                    d.wen    = alu_wen;
                    d.is_cmp = alu_cmp;
                    d.zres   = alu_zero;
                    d.st     = ST_WB;
                end
                ST_WB: begin
                    if (q.wen) d.regs[q.ir.dst] = q.res;
                    if (q.is_cmp) d.zero = q.zres;
                    d.ret     = 1'b1;
                    d.ret_wr  = q.wen;
                    d.ret_idx = q.ir.dst;
                    d.ret_val = q.wen ? q.res : '0;
                    d.st      = ST_FETCH;
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.halted <= 1'b1;
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_regout
        assign regs_flat[g*REG_W +: REG_W] = q.regs[g];
    end

    assign zero_flag  = q.zero;
    assign halted     = q.halted;
    assign retire     = q.ret;
    assign retire_wr  = q.ret_wr;
    assign retire_idx = q.ret_idx;
    assign retire_val = q.ret_val;

    // R7: strobe lasts exactly one cycle
    a_r7_retire_single: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // R8: a halted core never retires
    a_r8_halted_silent: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !retire);

    // R9: start always releases the halt on the next cycle
    a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !halted);

    // R9: a start cancels any retire due at the same edge
    a_r9_start_aborts: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !retire);

    // R6: the flag moves only with a retiring compare
    a_r6_zero_needs_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(zero_flag) |-> (retire && !retire_wr));

    // R4: registers change only with a writing retire
    a_r4_regs_need_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(regs_flat) |-> (retire && retire_wr));
endmodule

// File: tb/tb_seqcore.sv
module tb_seqcore;
    localparam int REG_W = 16;
    localparam int DEPTH = 32;
    localparam int PC_W  = 5;
    localparam int NVEC  = 18;

    typedef struct packed {
        logic [15:0]      word;
        logic [1:0]       idx;
        logic             wr;
        logic [REG_W-1:0] val;
        logic             zero;
        logic [3:0]       req;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{16'h040A, 2'd0, 1'b1, 16'h000A, 1'b0, 4'd2},  // R2 move imm 10
        '{16'h0CFD, 2'd1, 1'b1, 16'hFFFD, 1'b0, 4'd2},  // R2 move imm -3
        '{16'h2100, 2'd0, 1'b1, 16'h0007, 1'b0, 4'd3},  // R3 add
        '{16'h1000, 2'd2, 1'b1, 16'h0007, 1'b0, 4'd2},  // R2 move reg
        '{16'h5100, 2'd2, 1'b1, 16'h000A, 1'b0, 4'd3},  // R3 sub
        '{16'h6900, 2'd1, 1'b1, 16'h0009, 1'b0, 4'd3},  // R3 mul
        '{16'h8200, 2'd0, 1'b0, 16'h0000, 1'b0, 4'd4},  // R4 compare unequal
        '{16'h1C07, 2'd3, 1'b1, 16'h0007, 1'b0, 4'd2},  // R2 move imm 7
        '{16'h8300, 2'd0, 1'b0, 16'h0000, 1'b1, 4'd4},  // R4 compare equal
        '{16'h3C55, 2'd3, 1'b1, 16'h000E, 1'b1, 4'd10}, // R10 imm-select ignored
        '{16'hA800, 2'd1, 1'b1, 16'h0000, 1'b1, 4'd5},  // R5 op 5, R6 flag kept
        '{16'h9900, 2'd3, 1'b0, 16'h0000, 1'b0, 4'd4},  // R4 compare clears
        '{16'h1480, 2'd2, 1'b1, 16'hFF80, 1'b0, 4'd2},  // R2 sign extension
        '{16'h7200, 2'd2, 1'b1, 16'h4000, 1'b0, 4'd3},  // R3 mul
        '{16'h7200, 2'd2, 1'b1, 16'h0000, 1'b0, 4'd6},  // R6 zero result, flag kept; R3 truncation
        '{16'h4B00, 2'd1, 1'b1, 16'hFFF2, 1'b0, 4'd3},  // R3 sub wraps
        '{16'hE7FF, 2'd0, 1'b1, 16'h0000, 1'b0, 4'd5},  // R5 op 7
        '{16'hD800, 2'd3, 1'b1, 16'h0000, 1'b0, 4'd5}   // R5 op 6
    };

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  load_en;
    logic [PC_W-1:0]       load_addr;
    logic [15:0]           load_word;
    logic [PC_W:0]         prog_len;
    logic                  start;
    logic [4*REG_W-1:0]    regs_flat;
    logic                  zero_flag, halted, retire, retire_wr;
    logic [1:0]            retire_idx;
    logic [REG_W-1:0]      retire_val;

    int     checks = 0;
    int     fails  = 0;
    longint cyc    = 0;
    logic [REG_W-1:0] model [4];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seqcore #(.REG_W(REG_W), .IMEM_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
        .load_word(load_word), .prog_len(prog_len), .start(start),
        .regs_flat(regs_flat), .zero_flag(zero_flag), .halted(halted),
        .retire(retire), .retire_wr(retire_wr), .retire_idx(retire_idx),
        .retire_val(retire_val)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [REG_W-1:0] reg_of(input int i);
        return regs_flat[i*REG_W +: REG_W];
    endfunction

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic load(input int addr, input logic [15:0] w);
        load_en   = 1'b1;
        load_addr = PC_W'(addr);
        load_word = w;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic pulse_start(output longint t0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = cyc;
    endtask

    task automatic wait_retire(output bit ok);
        ok = 1'b0;
        for (int n = 0; n < 50; n++) begin
            @(negedge clk);
            if (retire) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        longint t0, tprev;
        bit     ok, quiet;
        rst_n = 1'b0; load_en = 1'b0; load_addr = '0; load_word = '0;
        prog_len = '0; start = 1'b0;
        for (int i = 0; i < 4; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 regs", 64'(regs_flat), 64'h0);
        check("R1 zero", 64'(zero_flag), 64'h0);
        check("R1 halted", 64'(halted), 64'h1);
        check("R1 retire", 64'(retire), 64'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 stays halted without start", 64'(halted), 64'h1);

        for (int i = 0; i < NVEC; i++) load(i, VEC[i].word);
        prog_len = (PC_W+1)'(NVEC);
        pulse_start(t0);
        tprev = t0;
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d step %0d", VEC[i].req, i);
            wait_retire(ok);
            check({tag, " retire seen"}, 64'(ok), 64'h1);
            check("R7 cycles per instruction", 64'(cyc - tprev), 64'd4);
            tprev = cyc;
            check({tag, " idx"}, 64'(retire_idx), 64'(VEC[i].idx));
            check({tag, " wr"}, 64'(retire_wr), 64'(VEC[i].wr));
            check({tag, " val"}, 64'(retire_val), 64'(VEC[i].val));
            check({tag, " zero"}, 64'(zero_flag), 64'(VEC[i].zero));
            if (VEC[i].wr) model[VEC[i].idx] = VEC[i].val;
            for (int r = 0; r < 4; r++)
                check({tag, " reg file"}, 64'(reg_of(r)), 64'(model[r]));
            @(negedge clk);
            check("R7 strobe one cycle", 64'(retire), 64'h0);
            tprev = tprev;
        end
        check("R8 halted after last word", 64'(halted), 64'h1);
        quiet = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (retire) quiet = 1'b0;
        end
        check("R8 no retire once halted", 64'(quiet), 64'h1);

        prog_len = '0;
        pulse_start(t0);
        check("R9 start releases halt", 64'(halted), 64'h0);
        @(negedge clk);
        check("R8 empty program halts", 64'(halted), 64'h1);
        check("R8 empty program retires nothing", 64'(retire), 64'h0);
        check("R9 registers kept over start", 64'(reg_of(1)), 64'hFFF2);

        load(0, 16'h0405);
        load(1, 16'h0D06);
        prog_len = (PC_W+1)'(2);
        pulse_start(t0);
        wait_retire(ok);
        check("R9 first word retires", 64'(retire_idx), 64'h0);
        check("R9 first word value", 64'(reg_of(0)), 64'h5);
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = cyc;
        check("R9 start on writeback kills strobe", 64'(retire), 64'h0);
        check("R9 start on writeback kills write", 64'(reg_of(1)), 64'hFFF2);
        check("R9 other register survives", 64'(reg_of(0)), 64'h5);
        check("R9 not halted after restart", 64'(halted), 64'h0);
        wait_retire(ok);
        check("R9 restart latency", 64'(cyc - t0), 64'd4);
        check("R9 restart from word 0", 64'(retire_idx), 64'h0);
        check("R9 restart value", 64'(retire_val), 64'h5);
        wait_retire(ok);
        check("R9 second word idx", 64'(retire_idx), 64'h1);
        check("R2 second word writes", 64'(reg_of(1)), 64'h6);
        repeat (2) @(negedge clk);
        check("R8 halted after two words", 64'(halted), 64'h1);
        finish_run();
    end
endmodule